// File: doc/BRIEF.md
# Bitfield Extract and Mask Unit

This is a combinational scalar-datapath helper. It either builds a contiguous bit mask or pulls a bit field out of a data word. An operation select picks three things: mask generation or field extraction, 32-bit or 64-bit width, and, for extraction only, zero fill or sign fill of the bits above the field. The unit returns a result and a condition flag with its write enable.

For extraction, the data word is the source and the control word carries both parameters. The offset sits in its lowest bits. A 7-bit length sits at bits 22:16. For mask generation, the data operand gives the run length and the control operand gives the start position. Both are taken modulo the operation width. Operand fetch, instruction decode and result write-back belong to the surrounding pipeline.

Top module: `bfx_unit`

## Requirements
- R1: `op_sel` encoding is as follows. Bit 2 = 1 selects extraction and 0 selects mask generation. Bit 1 = 1 selects 64-bit width and 0 selects 32-bit width. Bit 0 = 1 selects signed extraction and is ignored for mask generation. A 32-bit operation uses only bits 31:0 of both operands and drives `result[63:32]` to zero.
- R2: The extraction offset is `src_b[4:0]` at 32-bit width and `src_b[5:0]` at 64-bit width. The length is `src_b[22:16]` at both widths. All other bits of `src_b` have no effect on extraction.
- R3: Unsigned extraction returns the data shifted right by the offset, with only the low `length` bits kept and every bit above them zero.
- R4: Signed extraction copies the most significant extracted bit into every result bit above the field, up to the operation width.
- R5: A length of zero gives a zero result, for both signed and unsigned extraction.
- R6: When offset plus length exceeds the width, only the bits from the offset up to the top of the word are extracted, with no wrap-around. Signed extraction then sign-fills from bit width-1 of the data.
- R7: Extraction drives `scc_we` = 1 and `scc_out` = (result != 0).
- R8: 32-bit mask generation gives ((1 << (src_a & 31)) - 1) << (src_b & 31), truncated to 32 bits.
- R9: 64-bit mask generation gives ((1 << (src_a & 63)) - 1) << (src_b & 63), truncated to 64 bits.
- R10: Mask generation drives `scc_we` = 0 and `scc_out` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation select: [2] extract/mask, [1] 64/32-bit, [0] signed |
| src_a | input | 64 | Data word (extract) or run length (mask) |
| src_b | input | 64 | Control word (extract) or start position (mask) |
| result | output | 64 | Extracted field or generated mask |
| scc_out | output | 1 | Condition flag value |
| scc_we | output | 1 | Condition flag write enable |

## Verification
The in-design checks assume that every input is a settled two-state value when the combinational outputs are sampled. They also assume that the bits of `src_b` outside the offset and length fields carry arbitrary values. To meet this, the bench changes its inputs only on the rising clock edge and compares on the falling edge. Its directed and random control words deliberately set the unused upper control bits and the bit just above the offset field. The random stimulus draws lengths across the whole 0 to 127 range. This range covers zero, in-range and overflowing fields at both widths.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

  localparam int unsigned MAX_W = 64;

  // op_sel bit positions
  localparam int unsigned OP_EXT_BIT  = 2;
  localparam int unsigned OP_WIDE_BIT = 1;
  localparam int unsigned OP_SGN_BIT  = 0;

  // n low bits set; saturates at MAX_W
  function automatic logic [MAX_W-1:0] ones_below(input logic [7:0] n);
    logic [MAX_W-1:0] r;
    if (n >= 8'(MAX_W)) r = '1;
    else                r = (MAX_W'(1) << n) - MAX_W'(1);
    return r;
  endfunction

  // single bit at position n-1; zero when n is zero
  function automatic logic [MAX_W-1:0] top_bit(input logic [7:0] n);
    logic [MAX_W-1:0] r;
    if (n == 8'd0 || n > 8'(MAX_W)) r = '0;
    else                            r = MAX_W'(1) << (n - 8'd1);
    return r;
  endfunction

  // smaller of two field sizes
  function automatic logic [7:0] min8(input logic [7:0] a, input logic [7:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/bfx_mask_gen.sv
module bfx_mask_gen
  import bfx_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [SW-1:0] run_len,
  input  logic [SW-1:0] run_pos,
  output logic [W-1:0]  mask
);

  logic [MAX_W-1:0] ones_full;
  logic [W-1:0]     ones_w;

  always_comb begin
    ones_full = ones_below(8'(run_len));
    ones_w    = ones_full[W-1:0];
    mask      = ones_w << run_pos;
  end

  always_comb begin
    AST_MASK_POPCOUNT: assert ($countones(mask) <= int'(run_len))
      else $error("mask has more ones than its run length"); // R8
    if (run_pos != '0) begin
      AST_MASK_LOW_CLEAR: assert ((mask & ~({W{1'b1}} << run_pos)) == '0)
        else $error("mask has bits below its start position"); // R9
    end
  end

endmodule

// File: rtl/bfx_field_extract.sv
module bfx_field_extract
  import bfx_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter int unsigned LEN_W = 7,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]     data,
  input  logic [SW-1:0]    offset,
  input  logic [LEN_W-1:0] length,
  input  logic             sign_en,
  output logic [W-1:0]     field
);

  logic [W-1:0]     shifted;
  logic [7:0]       room;
  logic [7:0]       eff_len;
  logic [MAX_W-1:0] keep_full;
  logic [MAX_W-1:0] top_full;
  logic [W-1:0]     keep;
  logic [W-1:0]     base;
  logic             sign_bit;

  always_comb begin
    shifted   = data >> offset;
    room      = 8'(W) - 8'(offset);
    eff_len   = min8(8'(length), room);
    keep_full = ones_below(eff_len);
    top_full  = top_bit(eff_len);
    keep      = keep_full[W-1:0];
    base      = shifted & keep;
    sign_bit  = |(base & top_full[W-1:0]);
    field     = (sign_en && sign_bit) ? (base | ~keep) : base;
  end

  always_comb begin
    if (length == '0) begin
      AST_ZERO_LEN_ZERO: assert (field == '0)
        else $error("zero length gave nonzero field"); // R5
    end
    if (!sign_en && eff_len < 8'(W)) begin
      AST_UNSIGNED_FILL: assert ((field >> eff_len) == '0)
        else $error("bits above unsigned field not clear"); // R3
    end
    if (sign_en && sign_bit) begin
      AST_SIGN_FILL: assert (&(field | keep))
        else $error("bits above negative field not set"); // R4
    end
    AST_NO_WRAP: assert ((eff_len <= 8'(length)) && (int'(eff_len) + int'(offset) <= int'(W)))
      else $error("field extends past top of word"); // R6
  end

endmodule

// File: rtl/bfx_flag_unit.sv
module bfx_flag_unit #(
  parameter int unsigned W = 64
) (
  input  logic         is_extract,
  input  logic [W-1:0] value,
  output logic         flag,
  output logic         flag_we
);

  always_comb begin
    flag_we = is_extract;
    flag    = is_extract && (value != '0);
  end

endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned LEN_W   = 7,
  parameter int unsigned LEN_LSB = 16,
  localparam int unsigned NARROW_W = DATA_W / 2,
  localparam int unsigned CTRL_TOP = LEN_LSB + LEN_W
) (
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] result,
  output logic              scc_out,
  output logic              scc_we
);

  logic is_ext, is_wide, is_sgn;
  logic [DATA_W-1:0] ext_res [2];
  logic [DATA_W-1:0] msk_res [2];
  logic [LEN_W-1:0]  fld_len;

  assign is_ext  = op_sel[OP_EXT_BIT];
  assign is_wide = op_sel[OP_WIDE_BIT];
  assign is_sgn  = op_sel[OP_SGN_BIT];
  assign fld_len = src_b[CTRL_TOP-1:LEN_LSB];

  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^{src_b[DATA_W-1:CTRL_TOP], src_b[LEN_LSB-1:$clog2(DATA_W)]};

  // index 0: narrow width, index 1: full width
  for (genvar g = 0; g < 2; g++) begin : g_width
    localparam int unsigned WG  = (g == 0) ? NARROW_W : DATA_W;
    localparam int unsigned SWG = $clog2(WG);
    logic [WG-1:0] fld;
    logic [WG-1:0] msk;

    bfx_field_extract #(.W(WG), .LEN_W(LEN_W)) u_ext (
      .data   (src_a[WG-1:0]),
      .offset (src_b[SWG-1:0]),
      .length (fld_len),
      .sign_en(is_sgn),
      .field  (fld)
    );

    bfx_mask_gen #(.W(WG)) u_msk (
      .run_len(src_a[SWG-1:0]),
      .run_pos(src_b[SWG-1:0]),
      .mask   (msk)
    );

    assign ext_res[g] = DATA_W'(fld);
    assign msk_res[g] = DATA_W'(msk);
  end

  assign result = is_ext ? ext_res[is_wide] : msk_res[is_wide];

  bfx_flag_unit #(.W(DATA_W)) u_flag (
    .is_extract(is_ext),
    .value     (result),
    .flag      (scc_out),
    .flag_we   (scc_we)
  );

  always_comb begin
    if (!is_wide) begin
      AST_NARROW_UPPER_ZERO: assert (result[DATA_W-1:NARROW_W] == '0)
        else $error("narrow op drove upper result half"); // R1
    end
    if (!is_ext) begin
      AST_MASK_NO_FLAG: assert (!scc_we && !scc_out)
        else $error("mask op touched flag"); // R10
    end
    if (is_ext) begin
      AST_EXT_FLAG_TRACKS: assert (scc_we && (scc_out == (result != '0)))
        else $error("extract flag mismatch"); // R7
    end
  end

endmodule

// File: tb/bfx_unit_tb_top.sv
module bfx_unit_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  op_sel;
  logic [63:0] src_a, src_b;
  logic [63:0] result;
  logic        scc_out, scc_we;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  bfx_unit dut_i (
    .op_sel (op_sel),
    .src_a  (src_a),
    .src_b  (src_b),
    .result (result),
    .scc_out(scc_out),
    .scc_we (scc_we)
  );

  task automatic ref_model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                           output logic [63:0] r, output logic f, output logic we);
    int w, off, len, cnt, pos;
    w = op[1] ? 64 : 32;
    r = '0;
    if (op[2]) begin
      off = op[1] ? int'(b[5:0]) : int'(b[4:0]);
      len = int'(b[22:16]);
      cnt = 0;
      for (int i = 0; i < w; i++)
        if (i < len && off + i < w) begin r[i] = a[off+i]; cnt = i + 1; end
      if (op[0] && cnt > 0 && r[cnt-1])
        for (int i = cnt; i < w; i++) r[i] = 1'b1;
      we = 1'b1;
      f  = (r != 0);
    end else begin
      len = int'(a[5:0]) % w;
      pos = int'(b[5:0]) % w;
      for (int i = 0; i < w; i++)
        if (i >= pos && i < pos + len) r[i] = 1'b1;
      we = 1'b0;
      f  = 1'b0;
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                       input string tag);
    logic [63:0] er;
    logic ef, ew;
    @(posedge clk);
    op_sel = op; src_a = a; src_b = b;
    @(negedge clk);
    ref_model(op, a, b, er, ef, ew);
    n_checks++;
    if (result !== er || scc_out !== ef || scc_we !== ew) begin
      n_fail++;
      $display("FAIL %s op=%b a=%h b=%h: got r=%h f=%b we=%b, expected r=%h f=%b we=%b",
               tag, op, a, b, result, scc_out, scc_we, er, ef, ew);
    end
  endtask

  function automatic logic [63:0] ctl(input int len, input int off);
    return (64'(len) << 16) | 64'(off);
  endfunction

  initial begin
    op_sel = 3'b000; src_a = '0; src_b = '0;
    // initial all-zero inputs: mask op, empty result, flag untouched
    apply(3'b000, 64'd0, 64'd0, "R10");
    apply(3'b100, 64'hDEADBEEF, ctl(8, 4), "R3");
    apply(3'b100, 64'hFFFF_FFFF_DEAD_BEEF, ctl(12, 16), "R3");
    apply(3'b101, 64'h0000_0F00, ctl(4, 8), "R4");
    apply(3'b101, 64'h0000_0700, ctl(4, 8), "R4");
    apply(3'b111, 64'h8000_0000_0000_0000, ctl(1, 63), "R4");
    apply(3'b110, 64'hFFFF_FFFF_FFFF_FFFF, ctl(0, 5), "R5");
    apply(3'b101, 64'hFFFF_FFFF, ctl(0, 0), "R5");
    apply(3'b100, 64'hF000_0000, ctl(10, 28), "R6");
    apply(3'b101, 64'hF000_0000, ctl(10, 28), "R6");
    apply(3'b110, 64'hA000_0000_0000_0000, ctl(100, 60), "R6");
    apply(3'b111, 64'hA000_0000_0000_0000, ctl(127, 60), "R6");
    apply(3'b100, 64'h0000_00F8, ctl(4, 32 + 3) | 64'hFF80_0000_0000_0000, "R2");
    apply(3'b110, 64'h0000_00F8, ctl(4, 64 + 3) | 64'h0000_8000_0000_0000, "R2");
    apply(3'b100, 64'h0000_FF00, ctl(8, 0), "R7");
    apply(3'b110, 64'h1, ctl(5, 1), "R7");
    apply(3'b000, 64'd31, 64'd31, "R8");
    apply(3'b000, 64'd8 + 64'd32, 64'd28 + 64'd64, "R8");
    apply(3'b010, 64'd63 + 64'd64, 64'd4, "R9");
    apply(3'b010, 64'd20, 64'd50, "R9");
    apply(3'b001, 64'd5, 64'd3, "R1");
    apply(3'b101, 64'hFFFF_FFFF_8000_0000, ctl(64, 31), "R1");
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] op;
      logic [63:0] a, b;
      op = 3'($urandom_range(0, 7));
      a  = {$urandom, $urandom};
      b  = {$urandom, $urandom};
      if (k % 3 == 0) b[22:16] = 7'($urandom_range(0, 8));
      apply(op, a, b, op[2] ? (op[0] ? "R4" : "R3") : (op[1] ? "R9" : "R8"));
    end
    done = 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      done = 1;
    end
  end

  initial begin
    wait (done);
    #10;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule